// File: doc/BRIEF.md
# Two-Level Zero-Overhead Loop Sequencer

This block sits beside the fetch stage of a small 32-bit core. It lets a program run a short loop body many times with no branch instruction at the bottom of the body. A loop-setup instruction is presented at decode, together with its PC and the value of its first source register. The setup loads one of two loop levels with three values: a body start address, a body end address and an iteration count.

The fetch stage then presents each fetch PC to the block. When that PC equals the end address of a level that still has iterations left, the block raises a redirect request in the same cycle and supplies that level's start address. It also counts the level down by one. Level 0 is the inner loop and has priority over level 1. When level 0 runs out at an end address that level 1 shares, level 1 is evaluated in the same cycle.

Setup instructions use major opcode `1111011` and carry the level in bit 7. Two forms exist. The register form takes its count from the source register and a 12-bit end offset. The immediate form takes a 12-bit count and a 5-bit end offset.

Top module: `hw_loop_unit`

## Requirements
- R1: After reset both levels hold a count of zero, and no redirect is raised for any fetch PC.
- R2: A setup is accepted only when `setupValid` is high, bits 6:0 equal `1111011`, bits 11:8 equal `0000` and bits 14:12 equal `100` or `101`. Any other word, or any word presented with `setupValid` low, leaves both levels unchanged.
- R3: Register form (bits 14:12 = `100`): count = `rs1Value`; end = PC + (bits 31:20, unsigned) × 2; start = PC + 4.
- R4: Immediate form (bits 14:12 = `101`): count = bits 31:20 as an unsigned value; end = PC + (bits 19:15, unsigned) × 2; start = PC + 4.
- R5: Bit 7 of the setup word selects the level that is loaded: 0 for level 0, 1 for level 1. The other level is left unchanged.
- R6: A valid fetch at a level's end address, while that level's count is greater than 1, raises `redirectValid` in the same cycle with `redirectPc` equal to that level's start address, and the count drops by one.
- R7: A valid fetch at the end address of a level whose count is 1 drops the count to 0 and raises no redirect for that level. A level whose count is 0 never redirects.
- R8: When both levels would redirect at the same fetch PC, level 0 redirects and level 1 is left unchanged.
- R9: When level 0 reaches its last iteration at a PC that is also the level 1 end address, level 1 is evaluated in the same cycle and may redirect and count down.
- R10: While `fetchValid` is low, no redirect is raised and no count changes.
- R11: A setup that loads a level in the same cycle as a fetch-end decrement of that level takes effect in place of the decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| setupValid | input | 1 | A decoded instruction word is presented |
| setupInstr | input | 32 | Instruction word at decode |
| setupPc | input | ADDR_W | PC of that instruction |
| rs1Value | input | COUNT_W | Value of the first source register |
| fetchValid | input | 1 | Fetch PC is valid this cycle |
| fetchPc | input | ADDR_W | PC being fetched |
| redirectValid | output | 1 | Fetch must continue at redirectPc |
| redirectPc | output | ADDR_W | Start address of the level that loops back |

## Verification
The bench uses both setup forms with different offsets on both levels. For each loop it fetches the end address repeatedly and confirms that exactly count−1 redirects occur before the loop falls through, which separates an off-by-one count from a correct one. Separate patterns cover the following cases:
- Both levels sharing one end address, which tells the priority order apart from the fall-through into level 1.
- Malformed setup words and words presented with `setupValid` low.
- A zero count.
- Fetch PCs presented with `fetchValid` low.
- A setup colliding with a decrement in the same cycle, which tells load-wins from decrement-wins.

// File: rtl/hw_loop_unit_pkg.sv
package hw_loop_unit_pkg;

  localparam int unsigned LEVELS = 2;
  localparam logic [6:0] SETUP_OPCODE = 7'b1111011;
  localparam logic [2:0] FORM_REG = 3'b100;
  localparam logic [2:0] FORM_IMM = 3'b101;

  typedef struct packed {
    logic [LEVELS-1:0] load;
    logic [LEVELS-1:0] dec;
    logic [LEVELS-1:0] redirSel;
    logic              useImmForm;
  } loopStrobe_t;

endpackage

// File: rtl/hw_loop_unit_ctrl.sv
module hw_loop_unit_ctrl
  import hw_loop_unit_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned COUNT_W = 32
) (
  input  logic                           setupValid,
  input  logic [31:0]                    setupInstr,
  input  logic                           fetchValid,
  input  logic [ADDR_W-1:0]              fetchPc,
  input  logic [LEVELS-1:0][ADDR_W-1:0]  levelEnd,
  input  logic [LEVELS-1:0][COUNT_W-1:0] levelCount,
  output loopStrobe_t                    strb
);

  logic       opcodeOk;
  logic       padOk;
  logic [2:0] form;
  logic       formOk;
  logic       isSetup;
  logic       levelBit;

  assign opcodeOk = (setupInstr[6:0] == SETUP_OPCODE);
  assign padOk    = (setupInstr[11:8] == 4'b0000);
  assign form     = setupInstr[14:12];
  assign formOk   = (form == FORM_REG) || (form == FORM_IMM);
  assign isSetup  = setupValid && opcodeOk && padOk && formOk;
  assign levelBit = setupInstr[7];

  // Walk the levels from inner (0) to outer. The first level that loops
  // back blocks every level after it. A level that runs out lets the next
  // one be evaluated.
  always_comb begin
    logic blocked;
    strb            = '0;
    strb.useImmForm = (form == FORM_IMM);
    blocked         = 1'b0;
    for (int i = 0; i < LEVELS; i++) begin
      strb.load[i] = isSetup && (int'(levelBit) == i);
      if (fetchValid && !blocked && (levelCount[i] != '0) &&
          (fetchPc == levelEnd[i])) begin
        strb.dec[i] = 1'b1;
        if (levelCount[i] != COUNT_W'(1)) begin
          strb.redirSel[i] = 1'b1;
          blocked          = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/hw_loop_unit_dp.sv
module hw_loop_unit_dp
  import hw_loop_unit_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned COUNT_W = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  loopStrobe_t                    strb,
  input  logic [31:0]                    setupInstr,
  input  logic [ADDR_W-1:0]              setupPc,
  input  logic [COUNT_W-1:0]             rs1Value,
  output logic [LEVELS-1:0][ADDR_W-1:0]  levelEnd,
  output logic [LEVELS-1:0][COUNT_W-1:0] levelCount,
  output logic                           redirectValid,
  output logic [ADDR_W-1:0]              redirectPc
);

  logic [11:0]        wideField;
  logic [4:0]         narrowField;
  logic [ADDR_W-1:0]  newStart;
  logic [ADDR_W-1:0]  newEnd;
  logic [COUNT_W-1:0] newCount;
  logic [LEVELS-1:0][ADDR_W-1:0] levelStart;

  assign wideField   = setupInstr[31:20];
  assign narrowField = setupInstr[19:15];
  assign newStart    = setupPc + ADDR_W'(4);

  always_comb begin
    if (strb.useImmForm) begin
      newEnd   = setupPc + ADDR_W'({narrowField, 1'b0});
      newCount = COUNT_W'(wideField);
    end else begin
      newEnd   = setupPc + ADDR_W'({wideField, 1'b0});
      newCount = rs1Value;
    end
  end

  for (genvar g = 0; g < LEVELS; g++) begin : gLevel
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        levelStart[g] <= '0;
        levelEnd[g]   <= '0;
        levelCount[g] <= '0;
      end else if (strb.load[g]) begin
        levelStart[g] <= newStart;
        levelEnd[g]   <= newEnd;
        levelCount[g] <= newCount;
      end else if (strb.dec[g]) begin
        levelCount[g] <= levelCount[g] - COUNT_W'(1);
      end
    end
  end

  always_comb begin
    redirectPc = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (strb.redirSel[i]) redirectPc = redirectPc | levelStart[i];
    end
  end

  assign redirectValid = |strb.redirSel;

endmodule

// File: rtl/hw_loop_unit.sv
module hw_loop_unit
  import hw_loop_unit_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned COUNT_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               setupValid,
  input  logic [31:0]        setupInstr,
  input  logic [ADDR_W-1:0]  setupPc,
  input  logic [COUNT_W-1:0] rs1Value,
  input  logic               fetchValid,
  input  logic [ADDR_W-1:0]  fetchPc,
  output logic               redirectValid,
  output logic [ADDR_W-1:0]  redirectPc
);

  loopStrobe_t                    strb;
  logic [LEVELS-1:0][ADDR_W-1:0]  levelEnd;
  logic [LEVELS-1:0][COUNT_W-1:0] levelCount;

  hw_loop_unit_ctrl #(.ADDR_W(ADDR_W), .COUNT_W(COUNT_W)) ctrl_i (
    .setupValid (setupValid),
    .setupInstr (setupInstr),
    .fetchValid (fetchValid),
    .fetchPc    (fetchPc),
    .levelEnd   (levelEnd),
    .levelCount (levelCount),
    .strb       (strb)
  );

  hw_loop_unit_dp #(.ADDR_W(ADDR_W), .COUNT_W(COUNT_W)) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .setupInstr    (setupInstr),
    .setupPc       (setupPc),
    .rs1Value      (rs1Value),
    .levelEnd      (levelEnd),
    .levelCount    (levelCount),
    .redirectValid (redirectValid),
    .redirectPc    (redirectPc)
  );

endmodule

// File: rtl/hw_loop_unit_chk.sv
module hw_loop_unit_chk
  import hw_loop_unit_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned COUNT_W = 32
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           fetchValid,
  input logic                           redirectValid,
  input loopStrobe_t                    strb,
  input logic [LEVELS-1:0][COUNT_W-1:0] levelCount
);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (levelCount == '0));

  assert_fetch_gates_redirect_R10: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> fetchValid);

  assert_zero_counts_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    (levelCount == '0) |-> !redirectValid);

  assert_count_no_rise_lvl0_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load[0] |=> (levelCount[0] <= $past(levelCount[0])));

  assert_count_no_rise_lvl1_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load[1] |=> (levelCount[1] <= $past(levelCount[1])));

  assert_single_source_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.redirSel));

  assert_idle_fetch_keeps_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!fetchValid && (strb.load == '0)) |=> $stable(levelCount));

endmodule

bind hw_loop_unit hw_loop_unit_chk #(.ADDR_W(ADDR_W), .COUNT_W(COUNT_W)) chk_i (
  .clk           (clk),
  .rstN          (rstN),
  .fetchValid    (fetchValid),
  .redirectValid (redirectValid),
  .strb          (strb),
  .levelCount    (levelCount)
);

// File: tb/hw_loop_unit_tb_top.sv
module hw_loop_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        setupValid = 1'b0;
  logic [31:0] setupInstr = '0;
  logic [31:0] setupPc = '0;
  logic [31:0] rs1Value = '0;
  logic        fetchValid = 1'b0;
  logic [31:0] fetchPc = '0;
  logic        redirectValid;
  logic [31:0] redirectPc;

  int testsRun = 0;
  int testsFailed = 0;

  always #10 clk = ~clk;

  hw_loop_unit dut_i (
    .clk(clk), .rstN(rstN), .setupValid(setupValid), .setupInstr(setupInstr),
    .setupPc(setupPc), .rs1Value(rs1Value), .fetchValid(fetchValid),
    .fetchPc(fetchPc), .redirectValid(redirectValid), .redirectPc(redirectPc)
  );

  function automatic logic [31:0] encReg(logic lvl, logic [11:0] off12);
    return {off12, 5'd3, 3'b100, 4'b0000, lvl, 7'b1111011};
  endfunction

  function automatic logic [31:0] encImm(logic lvl, logic [11:0] cnt12, logic [4:0] off5);
    return {cnt12, off5, 3'b101, 4'b0000, lvl, 7'b1111011};
  endfunction

  task automatic check(string req, logic expV, logic [31:0] expPc);
    testsRun++;
    if (redirectValid !== expV || (expV && redirectPc !== expPc)) begin
      testsFailed++;
      $display("FAIL %s: actual valid=%0b pc=%h expected valid=%0b pc=%h",
               req, redirectValid, redirectPc, expV, expPc);
    end
  endtask

  task automatic issueSetup(logic [31:0] instr, logic [31:0] pc, logic [31:0] rs1, logic vld = 1'b1);
    @(negedge clk);
    setupValid = vld; setupInstr = instr; setupPc = pc; rs1Value = rs1;
    @(posedge clk); #1;
    setupValid = 1'b0; setupInstr = '0;
  endtask

  task automatic fetchAt(string req, logic [31:0] pc, logic expV, logic [31:0] expPc, logic vld = 1'b1);
    @(negedge clk);
    fetchValid = vld; fetchPc = pc;
    #5 check(req, expV, expPc);
    @(posedge clk); #1;
    fetchValid = 1'b0;
  endtask

  task automatic testReset();
    fetchAt("R1 reset quiet", 32'h0, 1'b0, 32'h0);
    fetchAt("R1 reset quiet", 32'h4, 1'b0, 32'h0);
  endtask

  task automatic testRegForm();
    // R3: pc 0x100, off 0x10 -> end 0x120, start 0x104, count 3
    issueSetup(encReg(1'b0, 12'h010), 32'h100, 32'd3);
    fetchAt("R3 non-end pc", 32'h11c, 1'b0, 32'h0);
    fetchAt("R6 iter1", 32'h120, 1'b1, 32'h104);
    fetchAt("R6 iter2", 32'h120, 1'b1, 32'h104);
    fetchAt("R7 last iter", 32'h120, 1'b0, 32'h0);
    fetchAt("R7 count zero", 32'h120, 1'b0, 32'h0);
  endtask

  task automatic testImmForm();
    // R4/R5: level 1, pc 0x200, count 2, off 0x1f -> end 0x23e, start 0x204
    issueSetup(encImm(1'b1, 12'd2, 5'h1f), 32'h200, 32'd99);
    fetchAt("R4 imm form redirect", 32'h23e, 1'b1, 32'h204);
    fetchAt("R4 imm form count", 32'h23e, 1'b0, 32'h0);
    // R5: level 0 load must not disturb level 1
    issueSetup(encImm(1'b1, 12'd3, 5'h02), 32'h600, 32'd0);
    issueSetup(encImm(1'b0, 12'd2, 5'h08), 32'h700, 32'd0);
    fetchAt("R5 level1 kept", 32'h604, 1'b1, 32'h604);
    fetchAt("R5 level0 loaded", 32'h710, 1'b1, 32'h704);
    fetchAt("R5 level1 kept", 32'h604, 1'b1, 32'h604);
    fetchAt("R5 level1 done", 32'h604, 1'b0, 32'h0);
    fetchAt("R5 level0 done", 32'h710, 1'b0, 32'h0);
  endtask

  task automatic testBadDecode();
    logic [31:0] good;
    good = encReg(1'b0, 12'h008); // pc 0x300 -> end 0x310
    issueSetup({good[31:7], 7'b0101011}, 32'h300, 32'd5);
    fetchAt("R2 wrong opcode", 32'h310, 1'b0, 32'h0);
    issueSetup(good | 32'h0000_0100, 32'h300, 32'd5);
    fetchAt("R2 pad bits set", 32'h310, 1'b0, 32'h0);
    issueSetup({good[31:15], 3'b110, good[11:0]}, 32'h300, 32'd5);
    fetchAt("R2 bad form", 32'h310, 1'b0, 32'h0);
    issueSetup(good, 32'h300, 32'd5, 1'b0);
    fetchAt("R2 setupValid low", 32'h310, 1'b0, 32'h0);
    issueSetup(good, 32'h300, 32'd0);
    fetchAt("R7 zero count load", 32'h310, 1'b0, 32'h0);
  endtask

  task automatic testNested();
    // level1: pc 0x400 off 0x20 -> end 0x440, start 0x404, count 3
    issueSetup(encReg(1'b1, 12'h020), 32'h400, 32'd3);
    // level0: pc 0x420 off 0x10 -> end 0x440, start 0x424, count 2
    issueSetup(encImm(1'b0, 12'd2, 5'h10), 32'h420, 32'd0);
    fetchAt("R8 inner wins", 32'h440, 1'b1, 32'h424);
    fetchAt("R9 fall to outer", 32'h440, 1'b1, 32'h404);
    fetchAt("R8 outer untouched by win", 32'h440, 1'b1, 32'h404);
    fetchAt("R7 outer last", 32'h440, 1'b0, 32'h0);
  endtask

  task automatic testFetchIdle();
    // pc 0x500 off 0x04 -> end 0x508, start 0x504, count 2
    issueSetup(encReg(1'b0, 12'h004), 32'h500, 32'd2);
    fetchAt("R10 idle no redirect", 32'h508, 1'b0, 32'h0, 1'b0);
    fetchAt("R10 idle no redirect", 32'h508, 1'b0, 32'h0, 1'b0);
    fetchAt("R10 count kept", 32'h508, 1'b1, 32'h504);
    fetchAt("R10 count kept", 32'h508, 1'b0, 32'h0);
  endtask

  task automatic testCollision();
    issueSetup(encReg(1'b0, 12'h004), 32'h500, 32'd2);
    @(negedge clk);
    setupValid = 1'b1; setupInstr = encReg(1'b0, 12'h004); setupPc = 32'h500; rs1Value = 32'd2;
    fetchValid = 1'b1; fetchPc = 32'h508;
    #5 check("R11 same-cycle redirect", 1'b1, 32'h504);
    @(posedge clk); #1;
    setupValid = 1'b0; fetchValid = 1'b0;
    fetchAt("R11 load wins", 32'h508, 1'b1, 32'h504);
    fetchAt("R11 load wins", 32'h508, 1'b0, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testRegForm();
    testImmForm();
    testBadDecode();
    testNested();
    testFetchIdle();
    testCollision();
    repeat (2) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog (all requirements): actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule